// File: doc/BRIEF.md
# Packed-Byte Matrix Multiply Core

This core computes the product of two square matrices of unsigned bytes and stores the product, also as bytes, in a result memory. Each matrix sits in its own single-port RAM with four bytes packed into each 32-bit word. The core runs by itself once triggered. It fetches one byte from each operand per cycle, accumulates the products of one row/column pair in a wide register, and gathers four finished result bytes into a word before it writes that word out.

A host fills the two operand RAMs and pulses `start`. The controller then sweeps the output elements in row-major order and signals completion with a one-cycle `done` pulse. Operand RAMs return read data one cycle after their enable. The result RAM is only ever written.

The controller has six states. `S_IDLE` waits for `start` and moves to `S_ISSUE`. `S_ISSUE` issues one operand read pair per cycle for each inner index and moves to `S_DRAIN` after the last one. `S_DRAIN` absorbs the final product and always moves to `S_PACK`. `S_PACK` places the low byte of the sum into its lane and clears the accumulator. From `S_PACK` the controller goes to `S_WRITE` when the lane was the last of its word, and back to `S_ISSUE` otherwise. `S_WRITE` stores the packed word and returns to `S_ISSUE`, or goes to `S_DONE` after the final word. `S_DONE` raises `done` and returns to `S_IDLE`.

Top module: `pmm_core`

## Requirements
- R1: After reset `done`, `a_en`, `b_en` and `c_en` are all low.
- R2: Element (r, c) of any matrix is held in word r*8 + c/4, byte lane c mod 4, and lane L occupies bits 8L+7 down to 8L. Lane 0 is bits 7:0.
- R3: Each result element C[i][k] equals the sum over j of A[i][j]*B[j][k], reduced modulo 256.
- R4: Partial sums are kept at full width and are never saturated or truncated before the final byte is taken. With every operand byte at 0xFF, every result byte is 0x20.
- R5: Each of the 256 result words is written exactly once, in ascending address order, and only after all four of its bytes are computed. Two writes never occur on consecutive cycles.
- R6: `done` is high for exactly one cycle per run, in the cycle right after the last result write.
- R7: A `start` pulse while a run is in progress has no effect. The run continues, its results are unchanged and only one `done` pulse appears.
- R8: While the core is idle after a run, no RAM enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| done | output | 1 | One-cycle completion pulse |
| a_en | output | 1 | Read enable, left operand RAM |
| a_addr | output | 8 | Word address, left operand RAM |
| a_rdata | input | 32 | Read data from left operand RAM, one cycle after enable |
| b_en | output | 1 | Read enable, right operand RAM |
| b_addr | output | 8 | Word address, right operand RAM |
| b_rdata | input | 32 | Read data from right operand RAM, one cycle after enable |
| c_en | output | 1 | Enable, result RAM |
| c_we | output | 1 | Write strobe, result RAM |
| c_addr | output | 8 | Word address, result RAM |
| c_wdata | output | 32 | Packed result word |

## Verification
The hardest case to reach is a `start` that arrives in the middle of a long run. The bench therefore pulses `start` at two fixed points deep inside one multiplication, one early and one roughly halfway through. It then confirms that the stream of result writes still matches the expected order and values and that only one `done` appears. Overflow of the wide sums is forced with all-ones operands, which drive every accumulator to its largest value. Lane placement is exposed by an identity left operand whose product must reproduce the right operand byte for byte.

// File: rtl/pmm_pkg.sv
`timescale 1ns/1ps
package pmm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_DRAIN,
        S_PACK,
        S_WRITE,
        S_DONE
    } pmm_state_t;
endpackage

// File: rtl/pmm_unpack.sv
`timescale 1ns/1ps
module pmm_unpack #(
    parameter int DW = 32,
    parameter int EW = 8,
    localparam int LANES = DW / EW,
    localparam int LW = $clog2(LANES)
) (
    input  logic [DW-1:0] word,
    input  logic [LW-1:0] lane,
    output logic [EW-1:0] elem
);
    logic [EW-1:0] slots [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_slot
        assign slots[g] = word[g*EW +: EW];
    end

    assign elem = slots[lane];
endmodule

// File: rtl/pmm_mac.sv
`timescale 1ns/1ps
module pmm_mac #(
    parameter int EW = 8,
    parameter int N  = 32,
    localparam int ACC_W = 2*EW + $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [EW-1:0]    a,
    input  logic [EW-1:0]    b,
    output logic [ACC_W-1:0] acc
);
    localparam int EMAX = (1 << EW) - 1;
    localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(N * EMAX * EMAX);

    logic [2*EW-1:0] prod;
    assign prod = a * b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= acc + ACC_W'(prod);
    end

    // R4: the sum of one element never exceeds N full-scale products
    a_r4_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_MAX);
endmodule

// File: rtl/pmm_pack.sv
`timescale 1ns/1ps
module pmm_pack #(
    parameter int DW = 32,
    parameter int EW = 8,
    localparam int LANES = DW / EW,
    localparam int LW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] lane,
    input  logic [EW-1:0] elem,
    output logic [DW-1:0] word
);
    logic [EW-1:0] slot_q [LANES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < LANES; g++) slot_q[g] <= '0;
        end else if (load) begin
            for (int g = 0; g < LANES; g++)
                if (lane == LW'(g)) slot_q[g] <= elem;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_word
        assign word[g*EW +: EW] = slot_q[g];
    end
endmodule

// File: rtl/pmm_core.sv
`timescale 1ns/1ps
module pmm_core #(
    parameter int N  = 32,
    parameter int EW = 8,
    parameter int DW = 32,
    localparam int LANES = DW / EW,
    localparam int LW    = $clog2(LANES),
    localparam int IW    = $clog2(N),
    localparam int AW    = 2*IW - LW,
    localparam int ACC_W = 2*EW + $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic          a_en,
    output logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_rdata,
    output logic          b_en,
    output logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_rdata,
    output logic          c_en,
    output logic          c_we,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_wdata
);
    import pmm_pkg::*;

    pmm_state_t    state, nxt;
    logic [IW-1:0] i_q, k_q, j_q;
    logic          rd_vld_q;
    logic [LW-1:0] lane_a_q;
    logic [EW-1:0] a_byte, b_byte;
    logic [ACC_W-1:0] acc;
    logic          last_j, last_lane, last_word;

    assign last_j    = (j_q == IW'(N-1));
    assign last_lane = (k_q[LW-1:0] == LW'(LANES-1));
    assign last_word = (i_q == IW'(N-1)) && (k_q == IW'(N-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_ISSUE;
            S_ISSUE: if (last_j) nxt = S_DRAIN;
            S_DRAIN: nxt = S_PACK;
            S_PACK:  nxt = last_lane ? S_WRITE : S_ISSUE;
            S_WRITE: nxt = last_word ? S_DONE : S_ISSUE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // loop indices and read pipeline tag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q      <= '0;
            k_q      <= '0;
            j_q      <= '0;
            rd_vld_q <= 1'b0;
            lane_a_q <= '0;
        end else begin
            rd_vld_q <= (state == S_ISSUE);
            lane_a_q <= j_q[LW-1:0];
            unique case (state)
                S_ISSUE: j_q <= j_q + 1'b1;
                S_PACK:  if (!last_lane) k_q <= k_q + 1'b1;
                S_WRITE: begin
                    k_q <= k_q + 1'b1;
                    if (k_q == IW'(N-1)) i_q <= i_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        a_en = 1'b0;
        b_en = 1'b0;
        c_en = 1'b0;
        c_we = 1'b0;
        done = 1'b0;
        unique case (state)
            S_ISSUE: begin a_en = 1'b1; b_en = 1'b1; end
            S_WRITE: begin c_en = 1'b1; c_we = 1'b1; end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign a_addr = {i_q, j_q[IW-1:LW]};
    assign b_addr = {j_q, k_q[IW-1:LW]};
    assign c_addr = {i_q, k_q[IW-1:LW]};

    pmm_unpack #(.DW(DW), .EW(EW)) u_unpack_a (
        .word(a_rdata), .lane(lane_a_q), .elem(a_byte));

    pmm_unpack #(.DW(DW), .EW(EW)) u_unpack_b (
        .word(b_rdata), .lane(k_q[LW-1:0]), .elem(b_byte));

    pmm_mac #(.EW(EW), .N(N)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(state == S_PACK), .en(rd_vld_q),
        .a(a_byte), .b(b_byte), .acc(acc));

    pmm_pack #(.DW(DW), .EW(EW)) u_pack (
        .clk(clk), .rst_n(rst_n), .load(state == S_PACK),
        .lane(k_q[LW-1:0]), .elem(acc[EW-1:0]), .word(c_wdata));

    a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(c_en));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_write_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        c_en |=> !c_en);

    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state inside {S_ISSUE, S_DRAIN, S_PACK, S_WRITE}) |=> (state != S_IDLE));
endmodule

// File: tb/sim_pmm_core.sv
`timescale 1ns/1ps
module sim_pmm_core;
    localparam int N = 32, EW = 8, DW = 32, LANES = 4, WPR = 8, DEPTH = 256, AW = 8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic done, a_en, b_en, c_en, c_we;
    logic [AW-1:0] a_addr, b_addr, c_addr;
    logic [DW-1:0] a_rdata, b_rdata, c_wdata;

    always #5 clk = ~clk;

    pmm_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .a_en(a_en), .a_addr(a_addr), .a_rdata(a_rdata),
        .b_en(b_en), .b_addr(b_addr), .b_rdata(b_rdata),
        .c_en(c_en), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata));

    logic [DW-1:0] mem_a [DEPTH];
    logic [DW-1:0] mem_b [DEPTH];
    logic [DW-1:0] mem_c [DEPTH];
    logic [DW-1:0] exp_c [DEPTH];

    always_ff @(posedge clk) begin
        if (a_en) a_rdata <= mem_a[a_addr];
        if (b_en) b_rdata <= mem_b[b_addr];
        if (c_en && c_we) mem_c[c_addr] <= c_wdata;
    end

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_t;
    wr_t exp_q [$];

    int total = 0, bad = 0, done_cnt = 0;
    logic prev_c_en = 1'b0, prev_done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] elem(input int pat, input int m, input int r, input int c);
        int v;
        case (pat)
            0: v = (m == 0) ? ((r == c) ? 1 : 0) : (r*3 + c*5 + 1);
            1: v = 255;
            default: v = (m == 0) ? (r*7 + c*13 + 5) : (((r*11) ^ (c*3)) + 2);
        endcase
        return v[7:0];
    endfunction

    // driver: fill operands (R2 layout) and push expected writes
    task automatic load(input int pat);
        for (int w = 0; w < DEPTH; w++) begin
            mem_a[w] = '0; mem_b[w] = '0; mem_c[w] = 32'h5A5A_5A5A;
        end
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                mem_a[r*WPR + c/LANES][8*(c%LANES) +: 8] = elem(pat, 0, r, c);
                mem_b[r*WPR + c/LANES][8*(c%LANES) +: 8] = elem(pat, 1, r, c);
            end
        exp_q.delete();
        for (int i = 0; i < N; i++)
            for (int w = 0; w < WPR; w++) begin
                wr_t e;
                e.addr = AW'(i*WPR + w);
                e.data = '0;
                for (int l = 0; l < LANES; l++) begin
                    int s = 0;
                    int k = w*LANES + l;
                    for (int j = 0; j < N; j++)
                        s += int'(elem(pat, 0, i, j)) * int'(elem(pat, 1, j, k));
                    e.data[8*l +: 8] = s[7:0];
                end
                exp_c[i*WPR + w] = e.data;
                exp_q.push_back(e);
            end
    endtask

    // monitor: pop and compare each result write
    always @(negedge clk) begin
        if (rst_n) begin
            if (c_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected write", longint'(c_addr), 0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(c_we, "R5", "write strobe", longint'(c_we), 1);
                    check(c_addr == e.addr, "R2", "write address", longint'(c_addr), longint'(e.addr));
                    check(c_wdata == e.data, "R3", "write data", longint'(c_wdata), longint'(e.data));
                end
            end
            if (done) begin
                done_cnt++;
                check(prev_c_en, "R6", "done not after last write", longint'(prev_c_en), 1);
                check(!prev_done, "R6", "done wider than one cycle", longint'(prev_done), 0);
            end
            prev_c_en = c_en;
            prev_done = done;
        end
    end

    task automatic run(input int pat, input bit poke);
        int mism;
        load(pat);
        done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (500) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (15000) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(done_cnt == 1, poke ? "R7" : "R6", "done pulse count", done_cnt, 1);
        check(exp_q.size() == 0, "R5", "missing writes", exp_q.size(), 0);
        check(!a_en && !b_en && !c_en && !done, "R8", "enable while idle",
              {a_en, b_en, c_en, done}, 0);
        mism = 0;
        for (int w = 0; w < DEPTH; w++) if (mem_c[w] !== exp_c[w]) mism++;
        check(mism == 0, "R2", "result memory readback mismatches", mism, 0);
        if (pat == 1)
            check(mem_c[0] == 32'h2020_2020, "R4", "all-ones wrap", longint'(mem_c[0]), 32'h2020_2020);
        if (pat == 0)
            check(mem_c[1] == mem_b[1], "R2", "identity row lanes", longint'(mem_c[1]), longint'(mem_b[1]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !a_en && !b_en && !c_en, "R1", "outputs in reset",
              {done, a_en, b_en, c_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !a_en && !b_en && !c_en, "R1", "outputs after reset",
              {done, a_en, b_en, c_en}, 0);
        run(0, 1'b0);   // R2, R3: identity left operand
        run(1, 1'b0);   // R4: full-scale operands
        run(2, 1'b1);   // R3, R7: mixed data with start pulses mid-run
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule